// File: doc/BRIEF.md
# Coherence Probe Queue with Tag-Only Lookup Mode

This block sits on the processor side of a coherence link. The system sends probe commands, each carrying a block address. The block holds up to eight of them in arrival order and runs a cache lookup for the oldest one. It then returns a probe response, and only at that moment does it free the entry. A matching credit counter tracks how many probes are outstanding, as the system side would. Its limit flag tells the sender to stop.

A configuration input selects how a lookup reaches the cache. In the default mode every lookup asks for the tag and the full block at once, on the expectation that a probe hits. In tag-only mode the first lookup asks for the tag alone. If that lookup hits, a second retry lookup fetches the block. A two-bit saturating hit-history counter follows the outcomes of recent tag-only lookups. While it shows a run of hits, the first lookup asks for data as well and the retry is skipped. This suits streamed traffic in which consecutive probes tend to hit.

The cache is reached through a request port and a result port. The result arrives on a valid strobe any number of cycles after the request, and only one lookup is outstanding at a time.

Top module: `snoop_queue`

## Requirements
- R1: After reset, rsp_valid, cache_req, sys_full and sys_outstanding are all zero.
- R2: sys_outstanding equals the number of probes accepted minus the responses issued, up to 8. sys_full is 1 exactly when it is 8, and the sender never presents a probe while sys_full is 1.
- R3: A probe entry stays counted until its response. sys_outstanding does not fall while a lookup is pending or when the cache result arrives. It still reads the old value in the cycle rsp_valid is high and falls by one in the next cycle.
- R4: Responses come out in the order the probes were accepted, and rsp_addr carries each probe's address.
- R5: In default mode (cfg_tag_only = 0) each probe causes exactly one lookup with cache_req_data = 1 at the probe's address. Every cache_req lasts one cycle.
- R6: A hit response has rsp_hit = 1, rsp_has_data = 1 and rsp_data equal to the block returned with data. A miss response has rsp_hit = 0, rsp_has_data = 0 and rsp_data = 0.
- R7: In tag-only mode, when a lookup made with cache_req_data = 0 hits, a retry lookup with cache_req_data = 1 at the same address is issued in the cycle after the result. The response then carries the block from the retry.
- R8: A lookup result that misses triggers no further lookup. rsp_valid is high, with no data, in the cycle after the result.
- R9: The hit history starts at 0 after reset. In tag-only mode it rises by one on each first-lookup hit (saturating at 3) and falls by one on each miss (saturating at 0). While it is 2 or more, the first lookup uses cache_req_data = 1 and no retry follows.
- R10: When a probe arrives in the same cycle as a response, sys_outstanding keeps its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_tag_only | input | 1 | 1 selects tag-only lookups with retry on hit |
| prb_valid | input | 1 | Probe command present this cycle |
| prb_addr | input | AW | Block address of the probe |
| sys_outstanding | output | CW | Probes sent and not yet answered |
| sys_full | output | 1 | Eight probes are pending; sender must hold |
| cache_req | output | 1 | Lookup request, one-cycle pulse |
| cache_req_addr | output | AW | Lookup address |
| cache_req_data | output | 1 | 1 asks for block data with the tag |
| cache_rsp_valid | input | 1 | Lookup result present |
| cache_rsp_hit | input | 1 | Lookup hit |
| cache_rsp_data | input | DW | Block data, meaningful when asked for |
| rsp_valid | output | 1 | Probe response issued this cycle |
| rsp_addr | output | AW | Address of the answered probe |
| rsp_hit | output | 1 | Probe hit in the cache |
| rsp_has_data | output | 1 | Response carries a block |
| rsp_data | output | DW | Block data of the response |

## Verification
Several properties are checked on every cycle. The credit count must track the queue occupancy, and no probe may be presented at the limit. Each cache request is a single pulse. A tag-only hit must be followed at once by a data retry, and a miss must turn directly into a data-less response. The queue occupancy must never fall outside a response cycle. Other behaviours need the bench's directed scenarios: arrival order across a full queue, the exact cycle an entry is released, block contents, and the sequence of retries and combined fetches as the hit history climbs, saturates and decays.

// File: rtl/snoop_pkg.sv
`timescale 1ns/1ps
package snoop_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LOOK,
    ST_WAIT,
    ST_RETRY,
    ST_RWAIT,
    ST_RESP
  } eng_state_e;

endpackage

// File: rtl/snoop_fifo.sv
`timescale 1ns/1ps
module snoop_fifo #(
  parameter int DEPTH = 8,
  parameter int AW    = 16,
  localparam int PW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  logic [AW-1:0] push_addr,
  input  logic          pop,
  output logic [AW-1:0] head_addr,
  output logic          empty,
  output logic [CW-1:0] count
);

  logic [PW-1:0] wr_q, wr_d;
  logic [PW-1:0] rd_q, rd_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          full;
  logic          push_ok;
  logic          pop_ok;
  logic [DEPTH-1:0][AW-1:0] ent_flat;

  function automatic logic [PW-1:0] step(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign full    = (cnt_q == CW'(DEPTH));
  assign empty   = (cnt_q == '0);
  assign pop_ok  = pop && !empty;
  assign push_ok = push && (!full || pop_ok);

  always_comb begin
    wr_d  = wr_q;
    rd_d  = rd_q;
    cnt_d = cnt_q;
    if (push_ok) wr_d = step(wr_q);
    if (pop_ok)  rd_d = step(rd_q);
    case ({push_ok, pop_ok})
      2'b10:   cnt_d = cnt_q + 1'b1;
      2'b01:   cnt_d = cnt_q - 1'b1;
      default: cnt_d = cnt_q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else begin
      wr_q  <= wr_d;
      rd_q  <= rd_d;
      cnt_q <= cnt_d;
    end
  end

  for (genvar i = 0; i < DEPTH; i++) begin : g_ent
    logic [AW-1:0] ent_q;
    logic          wen;
    assign wen = push_ok && (wr_q == PW'(i));
    always_ff @(posedge clk) begin
      if (wen) ent_q <= push_addr;
    end
    assign ent_flat[i] = ent_q;
  end

  assign head_addr = ent_flat[rd_q];
  assign count     = cnt_q;

endmodule

// File: rtl/snoop_credit.sv
`timescale 1ns/1ps
module snoop_credit #(
  parameter int DEPTH = 8,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          inc,
  input  logic          dec,
  output logic [CW-1:0] outstanding,
  output logic          at_limit
);

  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    case ({inc, dec})
      2'b10: if (cnt_q != CW'(DEPTH)) cnt_d = cnt_q + 1'b1;
      2'b01: if (cnt_q != '0)         cnt_d = cnt_q - 1'b1;
      default: cnt_d = cnt_q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign outstanding = cnt_q;
  assign at_limit    = (cnt_q == CW'(DEPTH));

endmodule

// File: rtl/snoop_hist.sv
`timescale 1ns/1ps
module snoop_hist #(
  parameter int HW     = 2,
  parameter int THRESH = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic hit,
  output logic predict
);

  localparam logic [HW-1:0] TOP = '1;

  logic [HW-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (en) begin
      if (hit) begin
        if (cnt_q != TOP) cnt_d = cnt_q + 1'b1;
      end else begin
        if (cnt_q != '0) cnt_d = cnt_q - 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign predict = (cnt_q >= HW'(THRESH));

endmodule

// File: rtl/snoop_engine.sv
`timescale 1ns/1ps
module snoop_engine
  import snoop_pkg::*;
#(
  parameter int AW = 16,
  parameter int DW = 64
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_tag_only,
  input  logic          q_empty,
  input  logic [AW-1:0] head_addr,
  input  logic          predict,
  output logic          hist_en,
  output logic          hist_hit,
  output logic          cache_req,
  output logic [AW-1:0] cache_req_addr,
  output logic          cache_req_data,
  input  logic          cache_rsp_valid,
  input  logic          cache_rsp_hit,
  input  logic [DW-1:0] cache_rsp_data,
  output logic          pop,
  output logic          rsp_valid,
  output logic          rsp_hit,
  output logic          rsp_has_data,
  output logic [DW-1:0] rsp_data
);

  eng_state_e    state_q, state_d;
  logic          want_q, want_d;
  logic          tmode_q, tmode_d;
  logic          hit_q, hit_d;
  logic          hasd_q, hasd_d;
  logic [DW-1:0] data_q, data_d;

  always_comb begin
    state_d        = state_q;
    want_d         = want_q;
    tmode_d        = tmode_q;
    hit_d          = hit_q;
    hasd_d         = hasd_q;
    data_d         = data_q;
    cache_req      = 1'b0;
    cache_req_data = 1'b0;
    hist_en        = 1'b0;
    pop            = 1'b0;
    case (state_q)
      ST_IDLE: begin
        if (!q_empty) state_d = ST_LOOK;
      end
      ST_LOOK: begin
        cache_req      = 1'b1;
        cache_req_data = !cfg_tag_only || predict;
        want_d         = cache_req_data;
        tmode_d        = cfg_tag_only;
        state_d        = ST_WAIT;
      end
      ST_WAIT: begin
        if (cache_rsp_valid) begin
          hist_en = tmode_q;
          if (cache_rsp_hit && !want_q) begin
            state_d = ST_RETRY;
          end else begin
            state_d = ST_RESP;
            hit_d   = cache_rsp_hit;
            hasd_d  = cache_rsp_hit;
            data_d  = cache_rsp_hit ? cache_rsp_data : '0;
          end
        end
      end
      ST_RETRY: begin
        cache_req      = 1'b1;
        cache_req_data = 1'b1;
        state_d        = ST_RWAIT;
      end
      ST_RWAIT: begin
        if (cache_rsp_valid) begin
          state_d = ST_RESP;
          hit_d   = 1'b1;
          hasd_d  = 1'b1;
          data_d  = cache_rsp_data;
        end
      end
      ST_RESP: begin
        pop     = 1'b1;
        state_d = ST_IDLE;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      want_q  <= 1'b0;
      tmode_q <= 1'b0;
      hit_q   <= 1'b0;
      hasd_q  <= 1'b0;
      data_q  <= '0;
    end else begin
      state_q <= state_d;
      want_q  <= want_d;
      tmode_q <= tmode_d;
      hit_q   <= hit_d;
      hasd_q  <= hasd_d;
      data_q  <= data_d;
    end
  end

  assign hist_hit       = cache_rsp_hit;
  assign cache_req_addr = head_addr;
  assign rsp_valid      = (state_q == ST_RESP);
  assign rsp_hit        = rsp_valid && hit_q;
  assign rsp_has_data   = rsp_valid && hasd_q;
  assign rsp_data       = rsp_valid ? data_q : '0;

endmodule

// File: rtl/snoop_queue.sv
`timescale 1ns/1ps
module snoop_queue #(
  parameter int DEPTH       = 8,
  parameter int AW          = 16,
  parameter int DW          = 64,
  parameter int HIST_W      = 2,
  parameter int HIST_THRESH = 2,
  localparam int CW         = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_tag_only,
  input  logic          prb_valid,
  input  logic [AW-1:0] prb_addr,
  output logic [CW-1:0] sys_outstanding,
  output logic          sys_full,
  output logic          cache_req,
  output logic [AW-1:0] cache_req_addr,
  output logic          cache_req_data,
  input  logic          cache_rsp_valid,
  input  logic          cache_rsp_hit,
  input  logic [DW-1:0] cache_rsp_data,
  output logic          rsp_valid,
  output logic [AW-1:0] rsp_addr,
  output logic          rsp_hit,
  output logic          rsp_has_data,
  output logic [DW-1:0] rsp_data
);

  logic [AW-1:0] head_addr;
  logic          q_empty;
  logic [CW-1:0] q_count;
  logic          pop;
  logic          predict;
  logic          hist_en;
  logic          hist_hit;

  snoop_fifo #(.DEPTH(DEPTH), .AW(AW)) u_fifo (
    .clk       (clk),
    .rst_n     (rst_n),
    .push      (prb_valid),
    .push_addr (prb_addr),
    .pop       (pop),
    .head_addr (head_addr),
    .empty     (q_empty),
    .count     (q_count)
  );

  snoop_credit #(.DEPTH(DEPTH)) u_credit (
    .clk         (clk),
    .rst_n       (rst_n),
    .inc         (prb_valid),
    .dec         (rsp_valid),
    .outstanding (sys_outstanding),
    .at_limit    (sys_full)
  );

  snoop_hist #(.HW(HIST_W), .THRESH(HIST_THRESH)) u_hist (
    .clk     (clk),
    .rst_n   (rst_n),
    .en      (hist_en),
    .hit     (hist_hit),
    .predict (predict)
  );

  snoop_engine #(.AW(AW), .DW(DW)) u_engine (
    .clk             (clk),
    .rst_n           (rst_n),
    .cfg_tag_only    (cfg_tag_only),
    .q_empty         (q_empty),
    .head_addr       (head_addr),
    .predict         (predict),
    .hist_en         (hist_en),
    .hist_hit        (hist_hit),
    .cache_req       (cache_req),
    .cache_req_addr  (cache_req_addr),
    .cache_req_data  (cache_req_data),
    .cache_rsp_valid (cache_rsp_valid),
    .cache_rsp_hit   (cache_rsp_hit),
    .cache_rsp_data  (cache_rsp_data),
    .pop             (pop),
    .rsp_valid       (rsp_valid),
    .rsp_hit         (rsp_hit),
    .rsp_has_data    (rsp_has_data),
    .rsp_data        (rsp_data)
  );

  assign rsp_addr = rsp_valid ? head_addr : '0;

endmodule

// File: rtl/snoop_queue_chk.sv
`timescale 1ns/1ps
module snoop_queue_chk #(
  parameter int CW = 4
) (
  input logic          clk,
  input logic          rst_n,
  input logic          prb_valid,
  input logic          sys_full,
  input logic [CW-1:0] sys_outstanding,
  input logic [CW-1:0] q_count,
  input logic          cache_req,
  input logic          cache_req_data,
  input logic          cache_rsp_valid,
  input logic          cache_rsp_hit,
  input logic          rsp_valid,
  input logic          rsp_hit,
  input logic          rsp_has_data
);

  logic last_req_data_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         last_req_data_q <= 1'b0;
    else if (cache_req) last_req_data_q <= cache_req_data;
  end

  // R2: the sender holds off while the limit flag is up
  p_no_overflow_r2: assert property (@(posedge clk) disable iff (!rst_n)
    prb_valid |-> !sys_full);

  // R10: the credit count and the queue occupancy agree on every cycle
  p_credit_match_r10: assert property (@(posedge clk) disable iff (!rst_n)
    sys_outstanding == q_count);

  // R5: a lookup request is a one-cycle pulse
  p_req_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
    cache_req |=> !cache_req);

  // R7: a tag-only hit is followed at once by a data retry
  p_retry_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (cache_rsp_valid && cache_rsp_hit && !last_req_data_q) |=> (cache_req && cache_req_data));

  // R8: a miss turns straight into a response without data
  p_miss_direct_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (cache_rsp_valid && !cache_rsp_hit) |=> (rsp_valid && !rsp_hit && !rsp_has_data && !cache_req));

  // R3: occupancy only falls after a response
  p_keep_until_rsp_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !rsp_valid |=> (q_count >= $past(q_count)));

endmodule

bind snoop_queue snoop_queue_chk #(.CW(CW)) u_chk (
  .clk             (clk),
  .rst_n           (rst_n),
  .prb_valid       (prb_valid),
  .sys_full        (sys_full),
  .sys_outstanding (sys_outstanding),
  .q_count         (q_count),
  .cache_req       (cache_req),
  .cache_req_data  (cache_req_data),
  .cache_rsp_valid (cache_rsp_valid),
  .cache_rsp_hit   (cache_rsp_hit),
  .rsp_valid       (rsp_valid),
  .rsp_hit         (rsp_hit),
  .rsp_has_data    (rsp_has_data)
);

// File: tb/snoop_queue_tb.sv
`timescale 1ns/1ps
module snoop_queue_tb;

  localparam int DEPTH = 8;
  localparam int AW    = 16;
  localparam int DW    = 64;
  localparam int CW    = $clog2(DEPTH + 1);

  logic          clk;
  logic          rst_n;
  logic          cfg_tag_only;
  logic          prb_valid;
  logic [AW-1:0] prb_addr;
  logic [CW-1:0] sys_outstanding;
  logic          sys_full;
  logic          cache_req;
  logic [AW-1:0] cache_req_addr;
  logic          cache_req_data;
  logic          cache_rsp_valid;
  logic          cache_rsp_hit;
  logic [DW-1:0] cache_rsp_data;
  logic          rsp_valid;
  logic [AW-1:0] rsp_addr;
  logic          rsp_hit;
  logic          rsp_has_data;
  logic [DW-1:0] rsp_data;

  int n_chk;
  int n_fail;
  bit done;
  bit hold;

  logic [AW-1:0] lk_addr [$];
  bit            lk_dat  [$];
  logic [AW-1:0] r_addr  [$];
  bit            r_hit   [$];
  bit            r_hd    [$];
  logic [DW-1:0] r_data  [$];

  snoop_queue u_dut (
    .clk             (clk),
    .rst_n           (rst_n),
    .cfg_tag_only    (cfg_tag_only),
    .prb_valid       (prb_valid),
    .prb_addr        (prb_addr),
    .sys_outstanding (sys_outstanding),
    .sys_full        (sys_full),
    .cache_req       (cache_req),
    .cache_req_addr  (cache_req_addr),
    .cache_req_data  (cache_req_data),
    .cache_rsp_valid (cache_rsp_valid),
    .cache_rsp_hit   (cache_rsp_hit),
    .cache_rsp_data  (cache_rsp_data),
    .rsp_valid       (rsp_valid),
    .rsp_addr        (rsp_addr),
    .rsp_hit         (rsp_hit),
    .rsp_has_data    (rsp_has_data),
    .rsp_data        (rsp_data)
  );

  initial begin
    clk = 1'b0;
    forever #2 clk = ~clk;
  end

  function automatic logic [DW-1:0] blk(input logic [AW-1:0] a);
    return {4{a}} ^ 64'h0123_4567_89AB_CDEF;
  endfunction

  function automatic bit resident(input logic [AW-1:0] a);
    return a[0];
  endfunction

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // cache model and response monitor, all on the falling edge
  initial begin : cache_model
    bit            pend;
    logic [AW-1:0] pa;
    bit            pd;
    pend = 0; pa = '0; pd = 0;
    cache_rsp_valid = 1'b0;
    cache_rsp_hit   = 1'b0;
    cache_rsp_data  = '0;
    forever begin
      @(negedge clk);
      if (!rst_n) begin
        pend = 0;
        cache_rsp_valid = 1'b0;
        cache_rsp_hit   = 1'b0;
        cache_rsp_data  = '0;
      end else begin
        if (pend && !hold) begin
          cache_rsp_valid = 1'b1;
          cache_rsp_hit   = resident(pa);
          cache_rsp_data  = pd ? blk(pa) : 64'hDEAD_BEEF_DEAD_BEEF;
          pend = 0;
        end else begin
          cache_rsp_valid = 1'b0;
          cache_rsp_hit   = 1'b0;
          cache_rsp_data  = '0;
        end
        if (cache_req) begin
          pend = 1;
          pa   = cache_req_addr;
          pd   = cache_req_data;
          lk_addr.push_back(cache_req_addr);
          lk_dat.push_back(cache_req_data);
        end
        if (rsp_valid) begin
          r_addr.push_back(rsp_addr);
          r_hit.push_back(rsp_hit);
          r_hd.push_back(rsp_has_data);
          r_data.push_back(rsp_data);
        end
      end
    end
  end

  task automatic do_reset(input bit tag);
    rst_n        = 1'b0;
    prb_valid    = 1'b0;
    prb_addr     = '0;
    cfg_tag_only = tag;
    hold         = 1'b0;
    repeat (3) @(negedge clk);
    lk_addr.delete(); lk_dat.delete();
    r_addr.delete(); r_hit.delete(); r_hd.delete(); r_data.delete();
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic send_burst(input logic [AW-1:0] a [], input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      prb_valid = 1'b1;
      prb_addr  = a[i];
    end
    @(negedge clk);
    prb_valid = 1'b0;
  endtask

  task automatic wait_rsp(input int n);
    int g;
    g = 0;
    while (r_addr.size() < n && g < 3000) begin
      @(negedge clk);
      g++;
    end
    @(negedge clk);
  endtask

  task automatic t_reset();
    do_reset(1'b0);
    chk("R1 rsp_valid", rsp_valid, 0);
    chk("R1 cache_req", cache_req, 0);
    chk("R1 sys_full", sys_full, 0);
    chk("R1 sys_outstanding", sys_outstanding, 0);
  endtask

  task automatic t_default();
    logic [AW-1:0] a [];
    a = new[4];
    a[0] = 16'h1235; a[1] = 16'h2240; a[2] = 16'h3371; a[3] = 16'h4482;
    do_reset(1'b0);
    send_burst(a, 4);
    wait_rsp(4);
    chk("R4 response count", r_addr.size(), 4);
    chk("R5 lookup count", lk_addr.size(), 4);
    for (int i = 0; i < 4; i++) begin
      if (i < r_addr.size()) begin
        chk("R4 order", r_addr[i], a[i]);
        chk("R6 hit flag", r_hit[i], resident(a[i]));
        chk("R6 data flag", r_hd[i], resident(a[i]));
        chk("R6 block", r_data[i], resident(a[i]) ? blk(a[i]) : '0);
      end
      if (i < lk_addr.size()) begin
        chk("R5 lookup addr", lk_addr[i], a[i]);
        chk("R5 lookup asks data", lk_dat[i], 1);
      end
    end
    chk("R2 drained", sys_outstanding, 0);
  endtask

  task automatic t_fill();
    logic [AW-1:0] a [];
    int g;
    a = new[DEPTH];
    for (int i = 0; i < DEPTH; i++) a[i] = AW'(16'h0500 + i * 3);
    do_reset(1'b0);
    hold = 1'b1;
    send_burst(a, DEPTH);
    chk("R2 outstanding at limit", sys_outstanding, DEPTH);
    chk("R2 limit flag", sys_full, 1);
    repeat (4) @(negedge clk);
    chk("R3 held while lookup pending", sys_outstanding, DEPTH);
    chk("R3 no response yet", r_addr.size(), 0);
    hold = 1'b0;
    g = 0;
    do begin
      @(negedge clk);
      g++;
    end while (!rsp_valid && g < 100);
    chk("R3 count during response", sys_outstanding, DEPTH);
    @(negedge clk);
    chk("R3 count after response", sys_outstanding, DEPTH - 1);
    chk("R2 limit flag cleared", sys_full, 0);
    g = 0;
    while (!rsp_valid && g < 100) begin
      @(negedge clk);
      g++;
    end
    prb_valid = 1'b1;
    prb_addr  = 16'h0600;
    @(negedge clk);
    prb_valid = 1'b0;
    chk("R10 same-cycle send and response", sys_outstanding, DEPTH - 1);
    wait_rsp(DEPTH + 1);
    chk("R4 response count", r_addr.size(), DEPTH + 1);
    for (int i = 0; i < DEPTH + 1; i++) begin
      if (i < r_addr.size())
        chk("R4 order full queue", r_addr[i], (i < DEPTH) ? a[i] : 16'h0600);
    end
    chk("R2 drained", sys_outstanding, 0);
  endtask

  task automatic t_tag();
    logic [AW-1:0] a [];
    bit pat [8];
    int h;
    int li;
    bit pred;
    pat = '{0, 1, 1, 1, 1, 0, 0, 1};
    a = new[8];
    for (int i = 0; i < 8; i++) a[i] = AW'(16'h0A00 + i * 2 + pat[i]);
    do_reset(1'b1);
    send_burst(a, 8);
    wait_rsp(8);
    chk("R7 response count", r_addr.size(), 8);
    h  = 0;
    li = 0;
    for (int i = 0; i < 8; i++) begin
      pred = (h >= 2);
      if (li < lk_addr.size()) begin
        chk("R9 first lookup data flag", lk_dat[li], pred);
        chk("R7 first lookup addr", lk_addr[li], a[i]);
      end
      li++;
      if (!pred && pat[i]) begin
        if (li < lk_addr.size()) begin
          chk("R7 retry asks data", lk_dat[li], 1);
          chk("R7 retry addr", lk_addr[li], a[i]);
        end
        li++;
      end
      if (i < r_addr.size()) begin
        chk("R8 response data flag", r_hd[i], pat[i]);
        chk("R7 response block", r_data[i], pat[i] ? blk(a[i]) : '0);
      end
      if (pat[i]) h = (h < 3) ? h + 1 : 3;
      else        h = (h > 0) ? h - 1 : 0;
    end
    chk("R8 total lookups", lk_addr.size(), li);
  endtask

  initial begin : watchdog
    #(4ns * 200000);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin : main
    n_chk  = 0;
    n_fail = 0;
    done   = 0;
    rst_n  = 1'b0;
    hold   = 1'b0;
    prb_valid = 1'b0;
    prb_addr  = '0;
    cfg_tag_only = 1'b0;
    t_reset();
    t_default();
    t_fill();
    t_tag();
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule